// File: doc/BRIEF.md
# SD Card Clock Generator

This block derives the clock that is driven to an SD card from a fast kernel clock. In normal operation the kernel clock is divided by a programmable integer (a 9-bit setting plus two), giving card clocks from half the kernel rate down to 1/513 of it. A bypass setting passes the kernel clock straight through instead. The output can be switched off, stopped while the card bus is idle to save power, or paused while the data FIFO is about to run dry or overflow. Every stop is glitch-free. The launch edge can be moved to the falling kernel-clock edge.

Configuration is written in a slower register clock domain. A hold register and a toggle handshake carry it into the kernel domain. Alongside the card clock, the block emits a single-kernel-cycle strobe for each card-clock transition, which the command and data engines use to launch and sample bits.

Top module: `sdclk_gen`

## Requirements
- R1: While and just after `ker_rst` is high, `card_clk` and `card_edge` are 0 and the active configuration is all zero: disabled, no bypass, divide setting 0. The clock therefore stays low until a write enables it.
- R2: With bypass clear and the clock running, each card-clock period lasts D+2 kernel cycles, where D is the 9-bit `cfg_div` value. The high phase lasts floor((D+2)/2) cycles and the low phase lasts the rest.
- R3: While the active enable bit is 0, `card_clk` stays low.
- R4: With power-save set, `card_clk` stays low while `bus_idle` is 1. With power-save clear, `bus_idle` has no effect and the clock keeps toggling.
- R5: With flow control set, `card_clk` stays low while `fifo_near_empty` or `fifo_near_full` is 1, and it resumes when both are 0. With flow control clear, these inputs have no effect.
- R6: With bypass set and the clock running, `card_clk` follows `ker_clk` and `cfg_div` is ignored. `card_edge` is 1 in every running cycle. A stop in this mode holds `card_clk` at 0, and the internal gate only changes while `ker_clk` is low.
- R7: With the falling-edge select set, each card-clock transition appears half a kernel cycle later than with it clear. This is at the kernel falling edge that follows the rising edge which raised `card_edge`.
- R8: In divided mode with rising-edge launch, `card_edge` is 1 in exactly those kernel cycles in which `card_clk` has just taken a new level.
- R9: A stop request (disable, idle stop or FIFO pause) never shortens a high phase. A high phase in progress always runs its full length, and the stop takes hold at the following falling edge.
- R10: A new divide value takes effect at the next falling edge of `card_clk`. The high phase in progress keeps its old length, and the low phase that follows uses the new value.
- R11: A write (`cfg_wr` high at a `reg_clk` rising edge) takes effect in the kernel domain within four kernel cycles. This holds for every write that follows the previous one by at least 3 kernel plus 2 register cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| reg_clk | input | 1 | Register-domain clock |
| reg_rst | input | 1 | Synchronous active-high reset, register domain |
| cfg_wr | input | 1 | Write strobe for the configuration fields |
| cfg_div | input | 9 | Divide setting D; period is D+2 kernel cycles |
| cfg_clk_en | input | 1 | Master enable of the card clock |
| cfg_bypass | input | 1 | Pass the kernel clock straight through |
| cfg_pwr_save | input | 1 | Stop the clock while the bus is idle |
| cfg_flow_ctl | input | 1 | Pause the clock on FIFO pressure |
| cfg_fall_edge | input | 1 | Launch transitions on the kernel falling edge |
| ker_clk | input | 1 | Kernel clock |
| ker_rst | input | 1 | Synchronous active-high reset, kernel domain |
| bus_idle | input | 1 | Card bus has no transfer in progress |
| fifo_near_empty | input | 1 | Transmit FIFO close to underrun |
| fifo_near_full | input | 1 | Receive FIFO close to overrun |
| card_clk | output | 1 | Clock to the card |
| card_edge | output | 1 | One-cycle strobe per card-clock transition |

## Verification
In rising-launch mode, the clock level and the strobe change one register stage after the kernel edge that decides them. The bench therefore samples both 2 ns after each kernel rising edge and measures the lengths of the high and low runs in whole kernel cycles. A configuration write reaches the divider three kernel edges after its register-clock edge. Every test waits for that window, and for any phase still in flight, before it takes a measurement. The first partial periods after a change are skipped. In falling-launch and bypass modes the output moves on the kernel falling edge, so the bench samples there as well. A FIFO or idle input is sampled at the next kernel edge, and the bench measures the high phase it interrupts to confirm that it runs its full length.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;
    localparam int DIV_W = 9;
    localparam int CNT_W = DIV_W + 1;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             en;
        logic             bypass;
        logic             pwr_save;
        logic             flow;
        logic             fall;
    } sdclk_cfg_t;

    localparam sdclk_cfg_t CFG_ZERO = '0;

    function automatic logic [CNT_W-1:0] period_len(input logic [DIV_W-1:0] d);
        return CNT_W'(d) + CNT_W'(2);
    endfunction

    function automatic logic [CNT_W-1:0] high_len(input logic [DIV_W-1:0] d);
        return period_len(d) >> 1;
    endfunction

    function automatic logic [CNT_W-1:0] low_len(input logic [DIV_W-1:0] d);
        return period_len(d) - high_len(d);
    endfunction
endpackage

// File: rtl/sdclk_cfg_sync.sv
module sdclk_cfg_sync
    import sdclk_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       reg_clk,
    input  logic       reg_rst,
    input  logic       wr,
    input  sdclk_cfg_t wr_cfg,
    input  logic       ker_clk,
    input  logic       ker_rst,
    output sdclk_cfg_t act_cfg
);
    localparam int CHAIN = SYNC_STAGES + 1;

    sdclk_cfg_t       hold_q;
    logic             tgl_q;
    logic [CHAIN-1:0] chain_q;
    logic             new_cfg;

    always_ff @(posedge reg_clk) begin
        if (reg_rst) begin
            hold_q <= CFG_ZERO;
            tgl_q  <= 1'b0;
        end else if (wr) begin
            hold_q <= wr_cfg;
            tgl_q  <= ~tgl_q;
        end
    end

    always_ff @(posedge ker_clk) begin
        if (ker_rst) chain_q <= '0;
        else         chain_q <= {chain_q[CHAIN-2:0], tgl_q};
    end

    assign new_cfg = chain_q[CHAIN-1] ^ chain_q[CHAIN-2];

    always_ff @(posedge ker_clk) begin
        if (ker_rst)      act_cfg <= CFG_ZERO;
        else if (new_cfg) act_cfg <= hold_q;
    end
endmodule

// File: rtl/sdclk_divider.sv
module sdclk_divider
    import sdclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div_req,
    input  logic             run,
    output logic             ck,
    output logic             edge_stb,
    output logic [DIV_W-1:0] div_live
);
    logic [CNT_W-1:0] cnt_q;
    logic             hi_done;
    logic             lo_done;

    assign hi_done = cnt_q >= (high_len(div_live) - CNT_W'(1));
    assign lo_done = cnt_q >= (low_len(div_live) - CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            ck       <= 1'b0;
            edge_stb <= 1'b0;
            cnt_q    <= '0;
            div_live <= '0;
        end else begin
            edge_stb <= 1'b0;
            if (ck) begin
                if (hi_done) begin
                    ck       <= 1'b0;
                    edge_stb <= 1'b1;
                    cnt_q    <= '0;
                    div_live <= div_req;
                end else begin
                    cnt_q <= cnt_q + CNT_W'(1);
                end
            end else if (lo_done) begin
                if (run) begin
                    ck       <= 1'b1;
                    edge_stb <= 1'b1;
                    cnt_q    <= '0;
                end else begin
                    div_live <= div_req;
                end
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/sdclk_bypass_gate.sv
module sdclk_bypass_gate (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic gate,
    output logic gated_clk
);
    always_ff @(negedge clk) begin
        if (rst) gate <= 1'b0;
        else     gate <= run;
    end

    assign gated_clk = clk & gate;
endmodule

// File: rtl/sdclk_gen.sv
module sdclk_gen
    import sdclk_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             reg_clk,
    input  logic             reg_rst,
    input  logic             cfg_wr,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic             cfg_clk_en,
    input  logic             cfg_bypass,
    input  logic             cfg_pwr_save,
    input  logic             cfg_flow_ctl,
    input  logic             cfg_fall_edge,
    input  logic             ker_clk,
    input  logic             ker_rst,
    input  logic             bus_idle,
    input  logic             fifo_near_empty,
    input  logic             fifo_near_full,
    output logic             card_clk,
    output logic             card_edge
);
    sdclk_cfg_t       wr_cfg;
    sdclk_cfg_t       act;
    logic             act_en, act_byp, act_ps, act_flow, act_fall;
    logic             stop_req, run_any, run_div, run_byp;
    logic             div_ck, div_edge, div_ck_fall;
    logic [DIV_W-1:0] div_live;
    logic             byp_gate, byp_clk;

    assign wr_cfg = '{div: cfg_div, en: cfg_clk_en, bypass: cfg_bypass,
                      pwr_save: cfg_pwr_save, flow: cfg_flow_ctl, fall: cfg_fall_edge};

    sdclk_cfg_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .reg_clk (reg_clk),
        .reg_rst (reg_rst),
        .wr      (cfg_wr),
        .wr_cfg  (wr_cfg),
        .ker_clk (ker_clk),
        .ker_rst (ker_rst),
        .act_cfg (act)
    );

    assign act_en   = act.en;
    assign act_byp  = act.bypass;
    assign act_ps   = act.pwr_save;
    assign act_flow = act.flow;
    assign act_fall = act.fall;

    assign stop_req = (act_ps & bus_idle) | (act_flow & (fifo_near_empty | fifo_near_full));
    assign run_any  = act_en & ~stop_req;
    assign run_div  = run_any & ~act_byp;
    assign run_byp  = run_any & act_byp;

    sdclk_divider u_div (
        .clk      (ker_clk),
        .rst      (ker_rst),
        .div_req  (act.div),
        .run      (run_div),
        .ck       (div_ck),
        .edge_stb (div_edge),
        .div_live (div_live)
    );

    always_ff @(negedge ker_clk) begin
        if (ker_rst) div_ck_fall <= 1'b0;
        else         div_ck_fall <= div_ck;
    end

    sdclk_bypass_gate u_gate (
        .clk       (ker_clk),
        .rst       (ker_rst),
        .run       (run_byp),
        .gate      (byp_gate),
        .gated_clk (byp_clk)
    );

    always_comb begin
        if (act_byp) begin
            card_clk  = byp_clk;
            card_edge = byp_gate;
        end else begin
            card_clk  = act_fall ? div_ck_fall : div_ck;
            card_edge = div_edge;
        end
    end
endmodule

// File: rtl/sdclk_gen_chk.sv
module sdclk_gen_chk
    import sdclk_pkg::*;
(
    input logic             ker_clk,
    input logic             ker_rst,
    input logic             ck,
    input logic             card_edge,
    input logic             en,
    input logic             bypass,
    input logic             pwr_save,
    input logic             flow,
    input logic             bus_idle,
    input logic             fifo_near_empty,
    input logic             fifo_near_full,
    input logic [DIV_W-1:0] div_live
);
    logic [CNT_W-1:0] hcnt_q;
    logic [DIV_W-1:0] div_hold_q;

    always_ff @(posedge ker_clk) begin
        if (ker_rst) begin
            hcnt_q     <= '0;
            div_hold_q <= '0;
        end else begin
            hcnt_q <= ck ? hcnt_q + CNT_W'(1) : '0;
            if (ck) div_hold_q <= div_live;
        end
    end

    AST_RESET_QUIET: assert property (@(posedge ker_clk)
        ker_rst |=> (!ck && !card_edge)); // R1

    AST_DISABLED_LOW: assert property (@(posedge ker_clk) disable iff (ker_rst)
        (!en && !ck) |=> !ck); // R3

    AST_IDLE_STOP: assert property (@(posedge ker_clk) disable iff (ker_rst)
        (pwr_save && bus_idle && !ck) |=> !ck); // R4

    AST_FIFO_PAUSE: assert property (@(posedge ker_clk) disable iff (ker_rst)
        (flow && (fifo_near_empty || fifo_near_full) && !ck) |=> !ck); // R5

    AST_STROBE_MARKS_EDGE: assert property (@(posedge ker_clk) disable iff (ker_rst)
        (!bypass && !$past(bypass)) |-> (card_edge == (ck != $past(ck)))); // R8

    AST_HIGH_UNSHORTENED: assert property (@(posedge ker_clk) disable iff (ker_rst)
        $fell(ck) |-> (hcnt_q == high_len(div_hold_q))); // R9
endmodule

bind sdclk_gen sdclk_gen_chk u_chk (
    .ker_clk         (ker_clk),
    .ker_rst         (ker_rst),
    .ck              (div_ck),
    .card_edge       (card_edge),
    .en              (act_en),
    .bypass          (act_byp),
    .pwr_save        (act_ps),
    .flow            (act_flow),
    .bus_idle        (bus_idle),
    .fifo_near_empty (fifo_near_empty),
    .fifo_near_full  (fifo_near_full),
    .div_live        (div_live)
);

// File: tb/sdclk_gen_tb.sv
module sdclk_gen_tb;
    logic       reg_clk = 1'b0, reg_rst = 1'b1, cfg_wr = 1'b0;
    logic [8:0] cfg_div = '0;
    logic       cfg_clk_en = 0, cfg_bypass = 0, cfg_pwr_save = 0, cfg_flow_ctl = 0, cfg_fall_edge = 0;
    logic       ker_clk = 1'b0, ker_rst = 1'b1;
    logic       bus_idle = 0, fifo_near_empty = 0, fifo_near_full = 0;
    logic       card_clk, card_edge;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #2.5 ker_clk = ~ker_clk;
    always #3.5 reg_clk = ~reg_clk;

    sdclk_gen u_dut (.*);

    // run-length monitor, sampled 2 ns after each kernel rising edge
    int hist_len [16];
    bit hist_lvl [16];
    int hcount = 0, run_len = 0, stb_err = 0;
    bit prev_ck = 0, chk_stb = 0;

    always begin
        @(posedge ker_clk);
        #2;
        if (card_clk !== prev_ck) begin
            if (hcount < 16) begin
                hist_lvl[hcount] = prev_ck;
                hist_len[hcount] = run_len;
            end
            hcount++;
            run_len = 1;
        end else begin
            run_len++;
        end
        if (chk_stb && (card_edge !== (card_clk !== prev_ck))) stb_err++;
        prev_ck = card_clk;
    end

    localparam int NV = 7;
    // {divide setting, expected high cycles, expected low cycles}
    localparam int TV [NV][3] = '{'{0, 1, 1}, '{1, 1, 2}, '{2, 2, 2}, '{3, 2, 3},
                                  '{9, 5, 6}, '{254, 128, 128}, '{511, 256, 257}};

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic kwait(input int n);
        repeat (n) @(posedge ker_clk);
    endtask

    task automatic wr_cfg(input int d, input bit en, input bit byp, input bit ps,
                          input bit fl, input bit fa);
        @(negedge reg_clk);
        cfg_div = 9'(d); cfg_clk_en = en; cfg_bypass = byp;
        cfg_pwr_save = ps; cfg_flow_ctl = fl; cfg_fall_edge = fa;
        cfg_wr = 1'b1;
        @(negedge reg_clk);
        cfg_wr = 1'b0;
        repeat (3) @(posedge ker_clk);
        repeat (2) @(posedge reg_clk);
    endtask

    task automatic count_hi(input int n, output int h);
        h = 0;
        repeat (n) begin
            @(posedge ker_clk);
            #2;
            if (card_clk === 1'b1) h++;
        end
    endtask

    task automatic clear_hist;
        @(negedge ker_clk);
        hcount = 0;
    endtask

    task automatic wait_rise;
        bit last;
        last = card_clk;
        for (int i = 0; i < 2000; i++) begin
            @(posedge ker_clk);
            #3;
            if (card_clk === 1'b1 && last === 1'b0) break;
            last = card_clk;
        end
    endtask

    task automatic finish_run;
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge ker_clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
            finish_run();
        end
    end

    initial begin
        int h, idx, t;
        bit c;
        kwait(4);
        @(negedge ker_clk);
        ker_rst = 0;
        reg_rst = 0;

        // R1: reset state and zero configuration keeps clock low
        #1;
        check(card_clk === 1'b0, "R1 card_clk after reset", int'(card_clk), 0);
        check(card_edge === 1'b0, "R1 card_edge after reset", int'(card_edge), 0);
        count_hi(30, h);
        check(h == 0, "R1 no clock before enable", h, 0);

        // R11: write latency to first rising edge
        @(negedge reg_clk);
        cfg_div = 9'd1; cfg_clk_en = 1; cfg_wr = 1;
        @(posedge reg_clk);
        t = 0;
        @(negedge reg_clk);
        cfg_wr = 0;
        while (card_clk !== 1'b1 && t < 20) begin
            @(posedge ker_clk);
            #1;
            t++;
        end
        check(t >= 1 && t <= 5, "R11 write to first edge cycles", t, 4);

        // R11: back-to-back writes at minimum spacing, last one wins
        wr_cfg(5, 1, 0, 0, 0, 0);
        wr_cfg(0, 0, 0, 0, 0, 0);
        wr_cfg(2, 1, 0, 0, 0, 0);
        kwait(20);
        chk_stb = 1;

        // R2/R8: table of divide settings
        for (int v = 0; v < NV; v++) begin
            int n;
            n = TV[v][1] + TV[v][2];
            wr_cfg(TV[v][0], 1, 0, 0, 0, 0);
            kwait(8);
            clear_hist();
            kwait(6 * n + 20);
            check(hcount >= 5, "R2 phases observed", hcount, 5);
            for (int k = 3; k < 5; k++) begin
                int e;
                e = hist_lvl[k] ? TV[v][1] : TV[v][2];
                check(hist_len[k] == e, hist_lvl[k] ? "R2 high length" : "R2 low length",
                      hist_len[k], e);
            end
        end
        check(stb_err == 0, "R8 strobe vs card_clk transitions", stb_err, 0);

        // R10: divide change mid-high takes effect at the falling edge
        wr_cfg(19, 1, 0, 0, 0, 0);
        kwait(50);
        clear_hist();
        wait_rise();
        idx = hcount;
        wr_cfg(1, 1, 0, 0, 0, 0);
        kwait(40);
        check(hist_lvl[idx] == 1 && hist_len[idx] == 10, "R10 old high kept", hist_len[idx], 10);
        check(hist_lvl[idx+1] == 0 && hist_len[idx+1] == 2, "R10 new low", hist_len[idx+1], 2);
        check(hist_lvl[idx+2] == 1 && hist_len[idx+2] == 1, "R10 new high", hist_len[idx+2], 1);

        // R9: FIFO pause raised mid-high does not shorten it
        wr_cfg(9, 1, 0, 0, 1, 0);
        kwait(30);
        clear_hist();
        wait_rise();
        idx = hcount;
        @(negedge ker_clk);
        fifo_near_full = 1;
        kwait(40);
        check(hist_lvl[idx] == 1 && hist_len[idx] == 5, "R9 high not shortened", hist_len[idx], 5);
        check(hcount == idx + 1, "R9 no further edges while paused", hcount, idx + 1);
        check(card_clk === 1'b0, "R9 held low", int'(card_clk), 0);
        @(negedge ker_clk);
        fifo_near_full = 0;
        count_hi(40, h);
        check(h > 0, "R5 resumes after pressure clears", h, 1);

        // R5: near-empty pauses with flow control, ignored without
        @(negedge ker_clk);
        fifo_near_empty = 1;
        kwait(10);
        count_hi(30, h);
        check(h == 0, "R5 paused on near empty", h, 0);
        wr_cfg(1, 1, 0, 0, 0, 0);
        fifo_near_full = 1;
        count_hi(30, h);
        check(h > 0, "R5 ignored when flow control off", h, 1);
        fifo_near_empty = 0;
        fifo_near_full = 0;

        // R4: idle stop
        bus_idle = 1;
        wr_cfg(1, 1, 0, 1, 0, 0);
        kwait(10);
        count_hi(30, h);
        check(h == 0, "R4 stopped while idle", h, 0);
        bus_idle = 0;
        count_hi(30, h);
        check(h > 0, "R4 runs when bus busy", h, 1);
        bus_idle = 1;
        wr_cfg(1, 1, 0, 0, 0, 0);
        count_hi(30, h);
        check(h > 0, "R4 idle ignored without power save", h, 1);
        bus_idle = 0;

        // R3: disable
        wr_cfg(1, 0, 0, 0, 0, 0);
        kwait(10);
        count_hi(30, h);
        check(h == 0, "R3 disabled holds low", h, 0);

        // R7: falling-edge launch
        chk_stb = 0;
        wr_cfg(3, 1, 0, 0, 0, 1);
        kwait(20);
        for (int i = 0; i < 50; i++) begin
            @(posedge ker_clk);
            #2;
            if (card_edge === 1'b1) break;
        end
        c = card_clk;
        check(card_edge === 1'b1, "R7 strobe seen", int'(card_edge), 1);
        @(negedge ker_clk);
        #2;
        check(card_clk !== c, "R7 transition at falling edge", int'(card_clk), int'(~c));

        // R6: bypass follows kernel clock, divider ignored
        wr_cfg(7, 1, 1, 0, 0, 0);
        kwait(6);
        for (int i = 0; i < 3; i++) begin
            @(posedge ker_clk);
            #1;
            check(card_clk === 1'b1 && card_edge === 1'b1, "R6 bypass high half",
                  int'(card_clk), 1);
            @(negedge ker_clk);
            #1;
            check(card_clk === 1'b0, "R6 bypass low half", int'(card_clk), 0);
        end
        fifo_near_empty = 1;
        wr_cfg(7, 1, 1, 0, 1, 0);
        kwait(4);
        count_hi(20, h);
        check(h == 0, "R6 bypass stopped by FIFO pause", h, 0);
        fifo_near_empty = 0;

        finish_run();
    end
endmodule